// File: doc/BRIEF.md
# Power-State LED Blink Controller

This block drives a single status LED pin whose pattern follows the system power state. Software supplies a 3-bit pattern code for each of the working (S0), suspend (S3) and soft-off (S5) states. It also supplies an enable for a fixed deep-suspend pattern and a bit that turns off output inversion. The surrounding logic supplies the current power state and a slow enable pulse every 1/8 s.

A 6-bit tick counter runs freely and is never cleared by a state or mode change. Every blink pattern is taken from it. The pattern code can hold the pin low, release it to high impedance, or blink it with one of several period and duty pairs. All outputs are registered and update only on a tick, so a change of state or code shows up at the next tick boundary and never makes a glitch shorter than one tick. The parameter `DS3_WIDE_DUTY` picks the duty of the fixed deep-suspend pattern: 75% when 1, 25% when 0.

Top module: `psled_ctrl`

## Requirements
- R1: While `rst_ni` is low and until the first tick after reset, `led_oe_o` is 1 and `led_o` is 1. This is the raw low level passed through the default inversion. The tick counter starts at 0.
- R2: Pattern code 000 gives a raw level of 0. The pin is driven low before inversion.
- R3: Pattern code 001 sets `led_oe_o` to 0. Every other code, and the deep-suspend pattern, sets `led_oe_o` to 1.
- R4: After the k-th tick since reset, let n = k mod 64. Code 010 is raw high when n mod 16 < 8 (0.5 Hz). Code 011 is raw high when n mod 8 < 4 (1 Hz).
- R5: Code 100 is raw high when n mod 64 < 32 (0.125 Hz, 50%). Code 101 is raw high when n mod 32 < 16 (0.25 Hz, 50%).
- R6: Code 110 is raw high when n mod 64 < 48 (0.125 Hz, 75%). Code 111 is raw high when n mod 32 < 24 (0.25 Hz, 75%).
- R7: When `pstate_i` is 3 (deep suspend) and `ds3_en_i` is 1, the S3 code is ignored. The raw level is high when n mod 32 < 24 if `DS3_WIDE_DUTY`=1, and when n mod 32 < 8 if it is 0. When `pstate_i` is 3 and `ds3_en_i` is 0, the S3 code is used.
- R8: `pstate_i` selects the code: 0 uses `mode_s0_i`, 1 uses `mode_s3_i`, 2 uses `mode_s5_i`, and 3 uses `mode_s3_i` unless R7 applies.
- R9: `led_o` is the raw level inverted when `inv_dis_i` is 0, and the raw level unchanged when it is 1.
- R10: `led_o` and `led_oe_o` change only on the clock edge where `tick_i` is high. They use the inputs sampled on that edge. A change of state or code does not restart the tick counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle enable every 1/8 s |
| pstate_i | input | 2 | Power state: 0 S0, 1 S3, 2 S5, 3 deep S3 |
| mode_s0_i | input | 3 | Pattern code used in S0 |
| mode_s3_i | input | 3 | Pattern code used in S3 |
| mode_s5_i | input | 3 | Pattern code used in S5 |
| ds3_en_i | input | 1 | Enables the fixed deep-suspend pattern |
| inv_dis_i | input | 1 | 1 turns off output inversion |
| led_o | output | 1 | Pin drive value |
| led_oe_o | output | 1 | Pin output enable (0 = high impedance) |

## Verification
The bench runs every pattern code through more than a full 64-tick counter cycle, with both polarities. A period divisor off by one bit, or a 75% window decoded as 25%, shows up as a phase mismatch within one cycle. Power-state changes are made mid-count; a design that clears the counter on a mode change would restart the phase and be caught. Deep suspend is run with the enable both off and on, and with a non-zero S3 code. This catches a design that ignores the S3 code when the enable is off, or lets the S3 code leak through when it is on. Inputs also change between ticks, so a design that reacts combinationally instead of at the tick edge would differ on the cycles in between.

// File: rtl/psled_ctrl.sv
module psled_ctrl #(
  parameter bit DS3_WIDE_DUTY = 1'b1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic [1:0] pstate_i,
  input  logic [2:0] mode_s0_i,
  input  logic [2:0] mode_s3_i,
  input  logic [2:0] mode_s5_i,
  input  logic       ds3_en_i,
  input  logic       inv_dis_i,
  output logic       led_o,
  output logic       led_oe_o
);
  localparam int CW = 6;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic [2:0]    mode_sel;
  logic          ds3_act;
  logic          raw;
  logic          drv_q;
  logic          oe_q;

  assign cnt_nx  = cnt_q + 1'b1;
  assign ds3_act = (pstate_i == 2'd3) && ds3_en_i;

  always_comb begin
    case (pstate_i)
      2'd0:    mode_sel = mode_s0_i;
      2'd2:    mode_sel = mode_s5_i;
      default: mode_sel = mode_s3_i;
    endcase
  end

  always_comb begin
    if (ds3_act) begin
      if (DS3_WIDE_DUTY) raw = (cnt_nx[4:3] != 2'b11);
      else               raw = (cnt_nx[4:3] == 2'b00);
    end else begin
      case (mode_sel)
        3'd2:    raw = ~cnt_nx[3];
        3'd3:    raw = ~cnt_nx[2];
        3'd4:    raw = ~cnt_nx[5];
        3'd5:    raw = ~cnt_nx[4];
        3'd6:    raw = (cnt_nx[5:4] != 2'b11);
        3'd7:    raw = (cnt_nx[4:3] != 2'b11);
        default: raw = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      drv_q <= 1'b1;
      oe_q  <= 1'b1;
    end else if (tick_i) begin
      cnt_q <= cnt_nx;
      drv_q <= raw ^ ~inv_dis_i;
      oe_q  <= ds3_act || (mode_sel != 3'd1);
    end
  end

  assign led_o    = drv_q;
  assign led_oe_o = oe_q;
endmodule

module psled_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic [1:0] pstate_i,
  input logic [2:0] mode_s0_i,
  input logic [2:0] mode_s5_i,
  input logic       ds3_en_i,
  input logic       inv_dis_i,
  input logic       led_o,
  input logic       led_oe_o
);
  a_r10_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> ($stable(led_o) && $stable(led_oe_o)));

  a_r3_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && tick_i && pstate_i == 2'd0 && mode_s0_i == 3'd1) |-> !led_oe_o);

  a_r7_ds3_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && tick_i && pstate_i == 2'd3 && ds3_en_i) |-> led_oe_o);

  a_r2_sink: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni && tick_i && pstate_i == 2'd2 && mode_s5_i == 3'd0)
      |-> (led_oe_o && led_o == !$past(inv_dis_i)));
endmodule

bind psled_ctrl psled_ctrl_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .pstate_i(pstate_i),
  .mode_s0_i(mode_s0_i), .mode_s5_i(mode_s5_i), .ds3_en_i(ds3_en_i),
  .inv_dis_i(inv_dis_i), .led_o(led_o), .led_oe_o(led_oe_o)
);

// File: tb/psled_ctrl_tb_top.sv
module psled_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] pstate = 2'd0;
  logic [2:0] m_s0 = 3'd0, m_s3 = 3'd0, m_s5 = 3'd0;
  logic       ds3_en = 1'b0;
  logic       inv_dis = 1'b0;
  logic       led, led_oe;

  int checks = 0;
  int errors = 0;
  int div = 0;
  int ticks = 0;
  bit exp_led = 1'b1;
  bit exp_oe = 1'b1;
  bit done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  psled_ctrl #(.DS3_WIDE_DUTY(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pstate_i(pstate),
    .mode_s0_i(m_s0), .mode_s3_i(m_s3), .mode_s5_i(m_s5),
    .ds3_en_i(ds3_en), .inv_dis_i(inv_dis), .led_o(led), .led_oe_o(led_oe)
  );

  function automatic bit pat(int code, int t);
    int p, q;
    case (code)
      2: begin p = 16; q = 2; end
      3: begin p = 8;  q = 2; end
      4: begin p = 64; q = 2; end
      5: begin p = 32; q = 2; end
      6: begin p = 64; q = 3; end
      7: begin p = 32; q = 3; end
      default: return 1'b0;
    endcase
    return ((t % p) * 4) < (p * q);
  endfunction

  // reference model: updates on the same edge as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      ticks = 0; exp_led = 1'b1; exp_oe = 1'b1;
    end else if (tick) begin
      int code;
      bit r;
      ticks = ticks + 1;
      code = (pstate == 2'd0) ? int'(m_s0) : (pstate == 2'd2) ? int'(m_s5) : int'(m_s3);
      if (pstate == 2'd3 && ds3_en) begin
        r = ((ticks % 32) < 24);
        exp_oe = 1'b1;
      end else begin
        r = pat(code, ticks);
        exp_oe = (code != 1);
      end
      exp_led = r ^ !inv_dis;
    end
  end

  task automatic compare();
    checks++;
    if (led_oe !== exp_oe || (exp_oe && led !== exp_led)) begin
      errors++;
      $display("FAIL %s t=%0d actual led=%b oe=%b expected led=%b oe=%b",
               cur_req, ticks, led, led_oe, exp_led, exp_oe);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      div = (div + 1) % 3;
      tick = rst_n && (div == 0);
    end
  endtask

  task automatic run_ticks(int n);
    step(n * 3);
  endtask

  initial begin
    step(4);
    cur_req = "R1";
    checks++;
    if (led !== 1'b1 || led_oe !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset actual led=%b oe=%b expected led=1 oe=1", led, led_oe);
    end
    rst_n = 1'b1;
    step(2);  // R1: no tick yet, outputs keep reset value
    for (int inv = 0; inv < 2; inv++) begin
      inv_dis = inv[0];
      for (int c = 0; c < 8; c++) begin
        m_s0 = c[2:0];
        case (c)
          0: cur_req = "R2";
          1: cur_req = "R3";
          2, 3: cur_req = "R4";
          4, 5: cur_req = "R5";
          default: cur_req = "R6";
        endcase
        if (inv == 1) cur_req = {cur_req, "/R9"};
        run_ticks(70);
      end
    end
    // R8: state selection, codes changed mid-count (R10: counter not restarted)
    cur_req = "R8";
    m_s0 = 3'd3; m_s3 = 3'd5; m_s5 = 3'd0; inv_dis = 1'b0;
    pstate = 2'd1; run_ticks(40);
    pstate = 2'd2; run_ticks(20);
    m_s5 = 3'd6;  step(1); run_ticks(40);
    pstate = 2'd0; run_ticks(20);
    // R7: deep suspend with the enable off then on
    cur_req = "R7";
    m_s3 = 3'd2; pstate = 2'd3; ds3_en = 1'b0; run_ticks(40);
    ds3_en = 1'b1; run_ticks(70);
    m_s3 = 3'd1; run_ticks(35);
    inv_dis = 1'b1; run_ticks(35);
    // R10: inputs toggle between ticks
    cur_req = "R10";
    for (int k = 0; k < 30; k++) begin
      step(1); pstate = k[1:0]; m_s0 = k[2:0];
      step(1); inv_dis = k[0];
      step(1);
    end
    run_ticks(5);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule